// File: doc/BRIEF.md
# Clock Divider Factor Calculator

This block takes a parent clock frequency and a requested output frequency, both unsigned integers, and works out the settings of a two-stage divider: a power-of-two pre-shift `p` followed by an integer divide of `m + 1`. It also reports the frequency those settings actually give. A clock-management controller pulses `start_i` with both rates on the inputs. Some tens of cycles later it reads `m_o`, `p_o` and `rate_o` in the cycle that `done_o` is high. Writing the settings into a clock control register and choosing the parent are left to the caller.

Internally, one serial restoring divider is used twice. The first pass finds the truncated ratio of parent to request. A combinational picker then chooses the exponent and the rounded-up divide count. The second pass divides the shifted parent by that count to get the achieved rate. The divide count is rounded up, so the rate chosen is the closest one at or below parent/ratio. The exponent is the smallest one that brings the ratio below 16.

Top module: `clkdiv_factor_calc`

## Requirements
- R1: A requested rate greater than the parent rate is treated as equal to the parent rate, which gives m = 0, p = 0 and an achieved rate equal to the parent rate.
- R2: A requested rate of zero is treated as 1.
- R3: With ratio = floor(parent / request) after R1 and R2, p is 0 when ratio < 16, 1 when ratio < 32, 2 when ratio < 64, and 3 otherwise.
- R4: The divide count is ceil(ratio / 2^p), and m_o equals the divide count minus 1. As a consequence, any result with p > 0 has m_o of at least 7.
- R5: rate_o equals floor((parent >> p) / divide_count). It never exceeds the parent rate.
- R6: When the ratio is above 128, the divide count saturates at 16, giving m_o = 15 and p_o = 3.
- R7: done_o is high for exactly one cycle per accepted start. m_o, p_o and rate_o change only in that cycle and otherwise hold their last result.
- R8: A start pulse while a calculation is in progress is ignored: the result reflects the operands captured when the calculation began.
- R9: A parent rate of zero gives m_o = 0, p_o = 0 and rate_o = 0.
- R10: After reset, done_o, m_o, p_o and rate_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a calculation (accepted only when idle) |
| parent_rate_i | input | 32 | Parent clock frequency |
| req_rate_i | input | 32 | Requested output frequency |
| m_o | output | 4 | Divider field, divide count minus 1 |
| p_o | output | 2 | Pre-shift exponent |
| rate_o | output | 32 | Achieved output frequency |
| done_o | output | 1 | One-cycle pulse when the outputs are valid |

## Verification
The bench sweeps every combination of small parent and request values, including zero on both sides and requests above the parent. This exposes a design that clamps in the wrong order or divides by zero: such a design would return garbage rates or report a divide of zero. A sweep with a larger parent walks the ratio across 15/16, 31/32, 63/64 and 120 to 200. A threshold off by one would then pick the wrong exponent, truncating instead of rounding up would give m one too small, and a missing saturation would wrap m past 15. Full-width operands check that the shifted division does not lose the top bits. A second start issued mid-calculation must not replace the captured operands, and the outputs must not move between done pulses.

// File: rtl/clkfc_pkg.sv
// Package: shared state encoding for the clock divider factor calculator.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package clkfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GO1   = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_PICK  = 3'd3,
        ST_GO2   = 3'd4,
        ST_WAIT2 = 3'd5
    } calc_state_t;

endpackage

// File: rtl/clkfc_serial_div.sv
// Module: clkfc_serial_div
// Unsigned restoring divider, one quotient bit per cycle, W cycles per divide.
// Assumes: divisor is non-zero when go_i is pulsed; go_i is only pulsed when
// the previous divide has finished. valid_o pulses one cycle with quot_o final.
module clkfc_serial_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         valid_o,
    output logic [W-1:0] quot_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, dsr_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, valid_q;
    logic [W:0]    shifted, rem_next;
    logic          fits;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        shifted  = {rem_q, quo_q[W-1]};
        fits     = (shifted >= {1'b0, dsr_q});
        rem_next = fits ? (shifted - {1'b0, dsr_q}) : shifted;
    end

    // Iteration registers: load on go, shift one bit per cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dsr_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go_i) begin
                rem_q <= '0;
                quo_q <= dividend_i;
                dsr_q <= divisor_i;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_next[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign quot_o  = quo_q;

endmodule

// File: rtl/clkfc_factor_pick.sv
// Module: clkfc_factor_pick
// Combinational choice of pre-shift exponent and rounded-up divide count.
// Assumes: ratio_i is the truncated parent/request ratio. The smallest
// exponent whose shifted ratio fits below 2^M_W is taken, else the largest.
// The count is clamped into 1 .. 2^M_W.
module clkfc_factor_pick #(
    parameter int W   = 32,
    parameter int M_W = 4,
    parameter int P_W = 2
) (
    input  logic [W-1:0]   ratio_i,
    output logic [P_W-1:0] p_o,
    output logic [M_W:0]   count_o
);
    localparam int          PMAX    = (1 << P_W) - 1;
    localparam logic [W:0]  CNT_MAX = (W+1)'(1) << M_W;
    localparam logic [W-1:0] LIM    = W'(1) << M_W;

    logic [P_W-1:0] p_sel;
    logic [W:0]     round_add, sum, cnt_full;

    // Exponent: scan downward so the smallest fitting exponent wins.
    always_comb begin
        p_sel = P_W'(PMAX);
        for (int i = PMAX; i >= 0; i--) begin
            if ((ratio_i >> i) < LIM) p_sel = P_W'(i);
        end
    end

    // Count: ceiling divide by 2^p, then clamp into the legal range.
    always_comb begin
        round_add = ((W+1)'(1) << p_sel) - (W+1)'(1);
        sum       = {1'b0, ratio_i} + round_add;
        cnt_full  = sum >> p_sel;
        if (cnt_full > CNT_MAX)
            cnt_full = CNT_MAX;
        else if (cnt_full == '0)
            cnt_full = (W+1)'(1);
    end

    assign p_o     = p_sel;
    assign count_o = cnt_full[M_W:0];

endmodule

// File: rtl/clkdiv_factor_calc.sv
// Module: clkdiv_factor_calc (top)
// Sequences clamp, ratio divide, factor pick and achieved-rate divide.
// Assumes: start_i is honoured only when idle; the outputs hold between
// done pulses. One shared serial divider serves both divides.
module clkdiv_factor_calc #(
    parameter int W   = 32,
    parameter int M_W = 4,
    parameter int P_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   parent_rate_i,
    input  logic [W-1:0]   req_rate_i,
    output logic [M_W-1:0] m_o,
    output logic [P_W-1:0] p_o,
    output logic [W-1:0]   rate_o,
    output logic           done_o
);
    import clkfc_pkg::*;

    calc_state_t    state_q;
    logic [W-1:0]   parent_q, req_q, ratio_q, req_clamped;
    logic [P_W-1:0] p_q, pick_p;
    logic [M_W:0]   cnt_q, pick_cnt;
    logic           div_go, div_valid;
    logic [W-1:0]   div_dividend, div_divisor, div_quot;
    logic           busy;

    // Request clamp: limit to the parent rate, then lift zero to one.
    always_comb begin
        req_clamped = (req_rate_i > parent_rate_i) ? parent_rate_i : req_rate_i;
        if (req_clamped == '0) req_clamped = W'(1);
    end

    // Divider operand select for the two passes.
    always_comb begin
        div_go       = (state_q == ST_GO1) || (state_q == ST_GO2);
        div_dividend = parent_q;
        div_divisor  = req_q;
        if (state_q == ST_GO2) begin
            div_dividend = parent_q >> p_q;
            div_divisor  = W'(cnt_q);
        end
    end

    assign busy = (state_q != ST_IDLE);

    clkfc_serial_div #(.W(W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_go),
        .dividend_i (div_dividend),
        .divisor_i  (div_divisor),
        .valid_o    (div_valid),
        .quot_o     (div_quot)
    );

    clkfc_factor_pick #(.W(W), .M_W(M_W), .P_W(P_W)) u_pick (
        .ratio_i (ratio_q),
        .p_o     (pick_p),
        .count_o (pick_cnt)
    );

    // Sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            parent_q <= '0;
            req_q    <= W'(1);
            ratio_q  <= '0;
            p_q      <= '0;
            cnt_q    <= (M_W+1)'(1);
            m_o      <= '0;
            p_o      <= '0;
            rate_o   <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    parent_q <= parent_rate_i;
                    req_q    <= req_clamped;
                    state_q  <= ST_GO1;
                end
                ST_GO1:   state_q <= ST_WAIT1;
                ST_WAIT1: if (div_valid) begin
                    ratio_q <= div_quot;
                    state_q <= ST_PICK;
                end
                ST_PICK: begin
                    p_q     <= pick_p;
                    cnt_q   <= pick_cnt;
                    state_q <= ST_GO2;
                end
                ST_GO2:   state_q <= ST_WAIT2;
                ST_WAIT2: if (div_valid) begin
                    rate_o  <= div_quot;
                    m_o     <= M_W'(cnt_q - (M_W+1)'(1));
                    p_o     <= p_q;
                    done_o  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/clkdiv_factor_calc_chk.sv
// Module: clkdiv_factor_calc_chk
// Property checker bound to the top; observes ports and the busy/parent state.
// Assumes: synchronous active-low reset shared with the design.
module clkdiv_factor_calc_chk #(
    parameter int W   = 32,
    parameter int M_W = 4,
    parameter int P_W = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [M_W-1:0] m_o,
    input logic [P_W-1:0] p_o,
    input logic [W-1:0]   rate_o,
    input logic           done_o,
    input logic           busy,
    input logic [W-1:0]   parent_q
);
    localparam logic [M_W-1:0] M_MIN_SHIFTED = M_W'((1 << (M_W - 1)) - 1);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({m_o, p_o, rate_o}));

    // R4
    shifted_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && p_o != '0) |-> (m_o >= M_MIN_SHIFTED));

    // R5
    rate_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rate_o <= parent_q));

    // R8
    done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

endmodule

bind clkdiv_factor_calc clkdiv_factor_calc_chk #(.W(W), .M_W(M_W), .P_W(P_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_o      (m_o),
    .p_o      (p_o),
    .rate_o   (rate_o),
    .done_o   (done_o),
    .busy     (busy),
    .parent_q (parent_q)
);

// File: tb/clkdiv_factor_calc_tb.sv
// Bench: sweeps small operands exhaustively plus ratio boundaries and
// full-width values, comparing against an arithmetic reference model.
module clkdiv_factor_calc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] parent_rate_i = '0;
    logic [31:0] req_rate_i = '0;
    logic [3:0]  m_o;
    logic [1:0]  p_o;
    logic [31:0] rate_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit hung = 0;

    always #10 clk = ~clk;  // 50 MHz

    clkdiv_factor_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .parent_rate_i(parent_rate_i), .req_rate_i(req_rate_i),
        .m_o(m_o), .p_o(p_o), .rate_o(rate_o), .done_o(done_o)
    );

    // Reference model built from the requirements.
    task automatic model(input longint par, input longint req,
                         output int em, output int ep, output longint er);
        longint r, ratio, cnt;
        r = req;
        if (r > par) r = par;          // R1
        if (r == 0) r = 1;             // R2
        ratio = par / r;
        if (ratio < 16) ep = 0;        // R3
        else if (ratio < 32) ep = 1;
        else if (ratio < 64) ep = 2;
        else ep = 3;
        cnt = (ratio + (1 << ep) - 1) >> ep;  // R4
        if (cnt > 16) cnt = 16;        // R6
        if (cnt == 0) cnt = 1;         // R9
        er = (par >> ep) / cnt;        // R5
        em = int'(cnt - 1);
    endtask

    task automatic check(input string tag, input longint am, input longint em,
                         input longint ap, input longint ep,
                         input longint ar, input longint er);
        checks++;
        if (am != em || ap != ep || ar != er) begin
            errors++;
            $display("FAIL %s: m=%0d p=%0d rate=%0d expected m=%0d p=%0d rate=%0d",
                     tag, am, ap, ar, em, ep, er);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1; break; end
        end
        if (!ok) begin
            checks++; errors++;
            $display("FAIL R7: no done pulse, actual 0 expected 1");
        end
    endtask

    task automatic run(input string tag, input longint par, input longint req);
        int em, ep; longint er; bit ok;
        model(par, req, em, ep, er);
        @(negedge clk);
        parent_rate_i = par[31:0];
        req_rate_i    = req[31:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(ok);
        if (ok) check(tag, m_o, em, p_o, ep, rate_o, er);
    endtask

    initial begin
        #4_000_000;
        hung = 1;
    end

    initial begin
        int em, ep; longint er; bit ok;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset", m_o, 0, p_o, 0, rate_o, 0);
        checks++;
        if (done_o !== 1'b0) begin
            errors++; $display("FAIL R10: done=%0b expected 0", done_o);
        end
        rst_n = 1'b1;

        // R1 R2 R9: exhaustive small sweep, includes zero and over-parent requests
        for (int par = 0; par <= 20 && !hung; par++)
            for (int req = 0; req <= 22; req++)
                run("R1/R2/R9 small sweep", par, req);

        // R3 R4 R6: ratio sweep across every threshold and the saturation point
        for (int req = 1; req <= 210 && !hung; req++)
            run("R3/R4/R6 ratio sweep", 210, req);
        for (int d = 1; d <= 200 && !hung; d++)
            run("R3/R4 exact ratio", 1000 * d, 1000);
        run("R6 saturate", 1_000_000, 7);
        run("R6 saturate", 129, 1);
        run("R6 edge 128", 128, 1);

        // R5 full-width operands
        run("R5 full width", 64'hFFFF_FFFF, 1);
        run("R5 full width", 64'hFFFF_FFFF, 64'h1000_0000);
        run("R1 full width", 64'hFFFF_FFFF, 64'hFFFF_FFFF);
        run("R5 mid", 24_000_000, 400_000);

        // R8: second start mid-calculation is ignored
        model(600, 25, em, ep, er);
        @(negedge clk);
        parent_rate_i = 600; req_rate_i = 25; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        parent_rate_i = 999; req_rate_i = 1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(ok);
        if (ok) begin
            check("R8 busy start ignored", m_o, em, p_o, ep, rate_o, er);
            // R7: pulse lasts one cycle and outputs hold afterwards
            @(negedge clk);
            checks++;
            if (done_o !== 1'b0) begin
                errors++; $display("FAIL R7: done=%0b expected 0", done_o);
            end
            repeat (80) @(negedge clk);
            checks++;
            if (done_o !== 1'b0) begin
                errors++; $display("FAIL R8: extra done=%0b expected 0", done_o);
            end
            check("R7 hold", m_o, em, p_o, ep, rate_o, er);
        end

        if (hung) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule